// File: doc/BRIEF.md
# BCD calendar clock with register mirror

This block keeps time of day and calendar date in packed BCD. It counts seconds, minutes, hours (00 to 23), weekday, day of month, month and two-digit year. Its timebase is a 32,768 Hz enable pulse. The live counters are not visible to the host. The host sees eight byte-wide registers in the topmost eight locations of a 13-bit byte address space: one control byte and seven time bytes that mirror the counters.

On every second boundary the counters advance. In the same clock edge the mirror takes the new time, unless the control byte blocks the copy. Three control bits set how the host works with the clock:
- **freeze** holds the mirror still, so that a multi-byte read is coherent.
- **load** opens the time bytes for writing. When load is cleared, the written values are pushed into the counters.
- **halt** stops the divider.

The remaining five control bits trim the length of one second per minute. This lets a slow or fast crystal be corrected.

Top module: `bcd_rtc_mirror`

## Requirements
- R1: After reset the control byte reads 0x00 and the time bytes read year 0x00, month 0x01, date 0x01, weekday 0x01, hour 0x00, minute 0x00, second 0x00.
- R2: The registers occupy addresses whose upper ten bits are all ones. The low three address bits select the register:
  - offset 0: control
  - offset 1: year
  - offset 2: month
  - offset 3: date
  - offset 4: weekday
  - offset 5: hour
  - offset 6: minute
  - offset 7: second

  Any other address reads 0x00, and a write to it changes no register.
- R3: The time advances by one second every TICKS_PER_SEC enabled ticks, with carries in BCD:
  - second and minute wrap from 0x59 to 0x00
  - hour wraps from 0x23 to 0x00
  - weekday wraps from 0x07 to 0x01
  - year wraps from 0x99 to 0x00

  When no blocking bit is set, the mirror shows the new time in the same edge as the counters.
- R4: The date rolls over to 0x01 after the last day of the month:
  - 30 days in months 0x04, 0x06, 0x09 and 0x11
  - 29 days in month 0x02 when the year is divisible by 4 (0x00 included), otherwise 28
  - 31 days in all other months
- R5: While control bit 7 (freeze) is set, the time bytes do not change, but the counters keep running. The first second boundary after freeze clears shows the running time.
- R6: Control bit 6 (load) governs writes to the time bytes:
  - Writes to the time bytes take effect only while load is set; at other times they are ignored.
  - A control write that clears load while it was set copies the seven time bytes into the counters and restarts the divider.
  - The next advance then comes exactly TICKS_PER_SEC ticks later.
- R7: While control bit 5 (halt) is set, the divider holds its count and the time does not advance. Counting resumes from the held count when halt clears.
- R8: Control bits 4:0 hold the calibration:
  - Bit 4 is the sign: 1 shortens, 0 lengthens.
  - Bits 3:0 are the magnitude in ticks.
  - The calibration changes the length of only the second during which the seconds count is 0x59.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable at the timebase rate (32,768 Hz) |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | Host write (1) or read (0) |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, combinational from the addressed register |

## Verification
The assertions assume the following about the host:
- It loads only legal BCD time values, with a date that exists in the loaded month and year.
- It keeps the calibration magnitude well below TICKS_PER_SEC, so that a second is never shorter than two ticks.

The stimulus stays inside these limits in two ways:
- Random times are drawn from the legal range of each field, with the date limited by the bench's own month-length function.
- Directed cases use hand-picked valid boundary dates.

The bench shrinks the second to 64 ticks, so that minute, day, month and year rollovers fall within a short run.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] wday;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    localparam int unsigned NUM_FIELDS = 7;

    // Control byte bit positions
    localparam int unsigned CTL_FREEZE = 7;
    localparam int unsigned CTL_LOAD   = 6;
    localparam int unsigned CTL_HALT   = 5;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // tens*10 + units is congruent to tens*2 + units modulo 4
    function automatic logic is_leap(input logic [7:0] yr);
        logic [3:0] s;
        s = {yr[6:4], 1'b0} + yr[3:0];
        return s[1:0] == 2'd0;
    endfunction

    function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic rtc_time_t time_advance(input rtc_time_t t);
        rtc_time_t n;
        n = t;
        if (t.sec != 8'h59) begin
            n.sec = bcd_inc(t.sec);
        end else begin
            n.sec = 8'h00;
            if (t.min != 8'h59) begin
                n.min = bcd_inc(t.min);
            end else begin
                n.min = 8'h00;
                if (t.hr != 8'h23) begin
                    n.hr = bcd_inc(t.hr);
                end else begin
                    n.hr   = 8'h00;
                    n.wday = (t.wday == 8'h07) ? 8'h01 : t.wday + 8'h01;
                    if (t.date != month_days(t.mon, t.yr)) begin
                        n.date = bcd_inc(t.date);
                    end else begin
                        n.date = 8'h01;
                        if (t.mon != 8'h12) begin
                            n.mon = bcd_inc(t.mon);
                        end else begin
                            n.mon = 8'h01;
                            n.yr  = (t.yr == 8'h99) ? 8'h00 : bcd_inc(t.yr);
                        end
                    end
                end
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
    parameter int unsigned TICKS_PER_SEC = 32768,
    parameter int unsigned MAG_W         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             halt,
    input  logic             restart,
    input  logic             last_sec,
    input  logic             cal_sign,
    input  logic [MAG_W-1:0] cal_mag,
    output logic             sec_pulse
);
    localparam int unsigned MAX_LEN = TICKS_PER_SEC + (1 << MAG_W);
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] BASE = CNT_W'(TICKS_PER_SEC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t       st_d, st_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        st_d      = st_q;
        sec_pulse = 1'b0;
        if (last_sec) lim = cal_sign ? BASE - CNT_W'(cal_mag) : BASE + CNT_W'(cal_mag);
        else          lim = BASE;
        if (restart) begin
            st_d.cnt = '0;
        end else if (tick_en && !halt) begin
            if (st_q.cnt >= lim - CNT_W'(1)) begin
                sec_pulse = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_halt_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !restart) |=> (st_q.cnt == $past(st_q.cnt)));

    assert_pulse_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> !sec_pulse);

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(MAX_LEN));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t now,
    output rtc_time_t nxt
);
    localparam rtc_time_t RESET_TIME = '{yr: 8'h00, mon: 8'h01, date: 8'h01,
                                         wday: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00};

    rtc_time_t cal_d, cal_q;

    always_comb begin
        nxt   = time_advance(cal_q);
        cal_d = cal_q;
        if (load)     cal_d = load_val;
        else if (adv) cal_d = nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cal_q <= RESET_TIME;
        else        cal_q <= cal_d;
    end

    assign now = cal_q;

    assert_date_in_month_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_q.date != 8'h00) && (cal_q.date <= month_days(cal_q.mon, cal_q.yr)));

    assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && cal_q.sec == 8'h59) |=> (cal_q.sec == 8'h00 && cal_q.min != $past(cal_q.min)));

    assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> $stable(cal_q));

endmodule

// File: rtl/bcd_rtc_mirror.sv
module bcd_rtc_mirror
    import rtc_pkg::*;
#(
    parameter int unsigned ADDR_W        = 13,
    parameter int unsigned TICKS_PER_SEC = 32768,
    parameter int unsigned CAL_MAG_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    localparam int unsigned CAL_SIGN = CAL_MAG_W;

    typedef struct packed {
        logic [7:0] ctrl;
        rtc_time_t  shadow;
    } top_state_t;

    top_state_t st_d, st_q;
    rtc_time_t  cal_now, cal_nxt;
    logic       sec_pulse, hit, wr_hit, ctrl_wr, commit;
    logic [2:0] off;

    always_comb begin
        hit    = bus_sel && (&bus_addr[ADDR_W-1:3]);
        off    = bus_addr[2:0];
        wr_hit = hit && bus_wr;
        ctrl_wr = wr_hit && (off == 3'd0);
        commit = ctrl_wr && st_q.ctrl[CTL_LOAD] && !bus_wdata[CTL_LOAD];

        st_d = st_q;
        if (ctrl_wr) st_d.ctrl = bus_wdata;
        if (wr_hit && off != 3'd0 && st_q.ctrl[CTL_LOAD]) begin
            for (int i = 1; i <= int'(NUM_FIELDS); i++) begin
                if (off == 3'(i)) st_d.shadow[(int'(NUM_FIELDS) - i) * 8 +: 8] = bus_wdata;
            end
        end else if (sec_pulse && !st_q.ctrl[CTL_FREEZE] && !st_q.ctrl[CTL_LOAD]) begin
            st_d.shadow = cal_nxt;
        end

        bus_rdata = 8'h00;
        if (hit) begin
            if (off == 3'd0) bus_rdata = st_q.ctrl;
            for (int i = 1; i <= int'(NUM_FIELDS); i++) begin
                if (off == 3'(i)) bus_rdata = st_q.shadow[(int'(NUM_FIELDS) - i) * 8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl   <= 8'h00;
            st_q.shadow <= '{yr: 8'h00, mon: 8'h01, date: 8'h01,
                             wday: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00};
        end else begin
            st_q <= st_d;
        end
    end

    rtc_divider #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .MAG_W        (CAL_MAG_W)
    ) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (osc_tick),
        .halt     (st_q.ctrl[CTL_HALT]),
        .restart  (commit),
        .last_sec (cal_now.sec == 8'h59),
        .cal_sign (st_q.ctrl[CAL_SIGN]),
        .cal_mag  (st_q.ctrl[CAL_MAG_W-1:0]),
        .sec_pulse(sec_pulse)
    );

    rtc_calendar cal_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (sec_pulse),
        .load    (commit),
        .load_val(st_q.shadow),
        .now     (cal_now),
        .nxt     (cal_nxt)
    );

    assert_freeze_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl[CTL_FREEZE] && !st_q.ctrl[CTL_LOAD]) |=> $stable(st_q.shadow));

    assert_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && off != 3'd0 && !st_q.ctrl[CTL_LOAD] && !sec_pulse) |=> $stable(st_q.shadow));

    assert_mirror_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !commit && !st_q.ctrl[CTL_FREEZE] && !st_q.ctrl[CTL_LOAD]) |=> (st_q.shadow == cal_now));

endmodule

// File: tb/bcd_rtc_mirror_tb_top.sv
module bcd_rtc_mirror_tb_top;
    localparam int TPS = 64;
    localparam logic [12:0] A_CTRL = 13'h1FF8, A_YR = 13'h1FF9, A_SEC = 13'h1FFF;

    typedef struct { int y; int mo; int d; int w; int h; int mi; int s; } tm_t;

    logic clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b1;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    int cyc = 0, w_edge = 0, total = 0, bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bcd_rtc_mirror #(.ADDR_W(13), .TICKS_PER_SEC(TPS), .CAL_MAG_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    function automatic logic [7:0] i2b(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dim(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic tm_t tm_next(tm_t t);
        tm_t n = t;
        n.s++;
        if (n.s == 60) begin n.s = 0; n.mi++; end
        if (n.mi == 60) begin n.mi = 0; n.h++; end
        if (n.h == 24) begin
            n.h = 0; n.w = (n.w == 7) ? 1 : n.w + 1; n.d++;
            if (n.d > dim(n.mo, n.y)) begin n.d = 1; n.mo++; end
            if (n.mo == 13) begin n.mo = 1; n.y = (n.y + 1) % 100; end
        end
        return n;
    endfunction

    function automatic logic [55:0] pack(tm_t t);
        return {i2b(t.y), i2b(t.mo), i2b(t.d), i2b(t.w), i2b(t.h), i2b(t.mi), i2b(t.s)};
    endfunction

    function automatic tm_t mk(int y, int mo, int d, int w, int h, int mi, int s);
        tm_t t;
        t.y = y; t.mo = mo; t.d = d; t.w = w; t.h = h; t.mi = mi; t.s = s;
        return t;
    endfunction

    task automatic check(string tag, logic [55:0] act, logic [55:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [12:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        w_edge = cyc;
    endtask

    task automatic rd(logic [12:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_to(int base, int n);
        while (cyc < base + n) @(negedge clk);
    endtask

    task automatic read_all(output logic [55:0] v);
        logic [7:0] b;
        for (int i = 1; i <= 7; i++) begin
            @(negedge clk);
            rd(A_CTRL + 13'(i), b);
            v[(7 - i) * 8 +: 8] = b;
        end
    endtask

    task automatic load(tm_t t, logic [7:0] ctl_after);
        logic [55:0] p = pack(t);
        wr(A_CTRL, 8'h40);
        for (int i = 1; i <= 7; i++) wr(A_CTRL + 13'(i), p[(7 - i) * 8 +: 8]);
        wr(A_CTRL, ctl_after);
    endtask

    task automatic step_case(string tag, tm_t t, int k);
        logic [55:0] got;
        tm_t e = t;
        int t0;
        load(t, 8'h00);
        t0 = w_edge;
        for (int i = 0; i < k; i++) e = tm_next(e);
        wait_to(t0, k * TPS + TPS / 2);
        read_all(got);
        check(tag, got, pack(e));
    endtask

    initial begin
        logic [7:0] b, b2;
        logic [55:0] got;
        tm_t t;
        int t0, h1;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk); rd(A_CTRL, b);
        check("R1 ctrl after reset", 56'(b), 56'h00);
        read_all(got);
        check("R1 time after reset", got, pack(mk(0, 1, 1, 1, 0, 0, 0)));

        // R2 decode: unmapped addresses
        wr(A_CTRL, 8'h40);
        @(negedge clk); rd(A_CTRL, b);
        check("R2 ctrl readback", 56'(b), 56'h40);
        @(negedge clk); rd(A_SEC, b);
        wr(13'h0FFF, 8'h42);
        wr(13'h1FF7, 8'h43);
        @(negedge clk); rd(A_SEC, b2);
        check("R2 unmapped write leaves second", 56'(b2), 56'(b));
        @(negedge clk); rd(13'h0FFF, b2);
        check("R2 unmapped read 0x0FFF", 56'(b2), 56'h00);
        @(negedge clk); rd(13'h1FF7, b2);
        check("R2 unmapped read 0x1FF7", 56'(b2), 56'h00);
        wr(A_CTRL, 8'h00);

        // R6 load timing and ignored writes
        load(mk(45, 7, 9, 3, 12, 34, 56), 8'h00);
        t0 = w_edge;
        wait_to(t0, TPS - 1); rd(A_SEC, b);
        check("R6 no advance before full second", 56'(b), 56'h56);
        wait_to(t0, TPS); rd(A_SEC, b);
        check("R6 advance one second after load", 56'(b), 56'h57);
        wr(A_YR, 8'h77);
        @(negedge clk); rd(A_YR, b);
        check("R6 year write ignored without load", 56'(b), 56'h45);

        // R3 / R4 directed boundaries
        step_case("R3 year wrap", mk(99, 12, 31, 7, 23, 59, 59), 1);
        step_case("R4 leap feb 28", mk(24, 2, 28, 3, 23, 59, 59), 1);
        step_case("R4 plain feb 28", mk(23, 2, 28, 3, 23, 59, 59), 1);
        step_case("R4 feb 29 year 00", mk(0, 2, 29, 2, 23, 59, 59), 1);
        step_case("R4 april 30", mk(21, 4, 30, 5, 23, 59, 59), 1);
        step_case("R4 january 31", mk(21, 1, 31, 6, 23, 59, 59), 1);
        step_case("R3 hour carry", mk(30, 6, 15, 4, 10, 59, 59), 1);
        step_case("R3 units nine carry", mk(30, 6, 15, 2, 10, 41, 9), 1);
        step_case("R3 two seconds", mk(30, 6, 15, 2, 10, 41, 58), 2);

        // R3 / R4 random legal times
        for (int n = 0; n < 24; n++) begin
            t.y  = int'($urandom_range(99, 0));
            t.mo = int'($urandom_range(12, 1));
            t.d  = int'($urandom_range(dim(t.mo, t.y), 1));
            t.w  = int'($urandom_range(7, 1));
            t.h  = ($urandom_range(1, 0) == 1) ? 23 : int'($urandom_range(23, 0));
            t.mi = ($urandom_range(1, 0) == 1) ? 59 : int'($urandom_range(59, 0));
            t.s  = int'($urandom_range(59, 55));
            step_case("R3 R4 random", t, int'($urandom_range(3, 1)));
        end

        // R5 freeze
        t = mk(50, 5, 5, 5, 5, 5, 5);
        load(t, 8'h00);
        t0 = w_edge;
        wr(A_CTRL, 8'h80);
        wait_to(t0, 3 * TPS + TPS / 2);
        read_all(got);
        check("R5 frozen mirror", got, pack(t));
        wr(A_CTRL, 8'h00);
        wait_to(t0, 4 * TPS + TPS / 2);
        read_all(got);
        check("R5 after unfreeze shows running time", got, pack(tm_next(tm_next(tm_next(tm_next(t))))));

        // R7 halt
        load(mk(50, 5, 5, 5, 5, 5, 20), 8'h00);
        t0 = w_edge;
        wr(A_CTRL, 8'h20);
        wait_to(t0, 5 * TPS); rd(A_SEC, b);
        check("R7 halted second", 56'(b), 56'h20);
        wr(A_CTRL, 8'h00);
        h1 = w_edge;
        wait_to(h1, TPS / 2); rd(A_SEC, b);
        check("R7 resumed from held count", 56'(b), 56'h20);
        wait_to(h1, TPS + TPS / 2); rd(A_SEC, b);
        check("R7 advance after halt", 56'(b), 56'h21);

        // R8 calibration, shorten by 15
        load(mk(10, 3, 3, 3, 3, 0, 58), 8'h1F);
        t0 = w_edge;
        wait_to(t0, TPS - 1); rd(A_SEC, b);
        check("R8 normal second unchanged", 56'(b), 56'h58);
        wait_to(t0, 2 * TPS - 17); rd(A_SEC, b);
        check("R8 short second not yet over", 56'(b), 56'h59);
        wait_to(t0, 2 * TPS - 13); rd(A_SEC, b);
        check("R8 short second over", 56'(b), 56'h00);

        // R8 calibration, lengthen by 15
        load(mk(10, 3, 3, 3, 3, 0, 58), 8'h0F);
        t0 = w_edge;
        wait_to(t0, 2 * TPS + 12); rd(A_SEC, b);
        check("R8 long second still running", 56'(b), 56'h59);
        wait_to(t0, 2 * TPS + 17); rd(A_SEC, b);
        check("R8 long second over", 56'(b), 56'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule